// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Back End

This block sits behind a ten-stage pipelined converter and turns the stage decisions into one output word. Every redundant stage except the last resolves its residue into one of three levels (codes 0, 1, 2). The last stage resolves a single bit. Because a sample moves down the analog pipeline by one stage per half conversion clock, the codes of one sample reach the block spread over ten half-cycles. The block delays each stage's code by the right number of half-cycles so that all codes of one sample line up. It then adds them with binary weights that overlap by one bit. This overlap lets a later stage cancel a wrong decision made by an earlier comparator, so the result has no missing codes.

The block runs on a clock at twice the conversion rate, and every cycle of `clk_i` is one half conversion cycle. An internal phase bit alternates between a launch half and an off half. A sample starts only in a launch half. The corrected sum is offset to straight binary with mid-scale at 10_0000_0000. It is saturated at the code limits and shown on a registered output. That output changes only at the edge that closes a launch half, which corresponds to the rising edge of the conversion clock. A stage code of 3 can only come from a faulty comparator pair. It is replaced and reported on an error flag that travels with its sample.

Top module: `adc_pipe_corr`

## Requirements
- R1: The corrected value is the sum over slots k = 0..8 of code_k * 2^(9-k), plus the final-stage bit from slot 9 (1 when its code is non-zero), minus 511. Slot k sits at bits [2k+1:2k] of `stg_code_i`, and slot 0 is the first stage.
- R2: In any half-cycle, slot k carries the code for the sample that was launched k half-cycles earlier. Samples launched one full cycle apart overlap on the bus and must still be combined correctly.
- R3: A launched sample appears on `word_o` with `word_vld_o` high 11 half-cycles after its launch, which is 5.5 conversion cycles. It stays there for two half-cycles. With no launch behind it, `word_vld_o` is low.
- R4: The first half-cycle after reset is a launch half, and launch and off halves alternate from then on. A `smp_vld_i` pulse in an off half is ignored and never produces a valid word.
- R5: A corrected value below 0 gives 0, and a value above 1023 gives 1023.
- R6: A code of 3 on a redundant slot counts as 2. A code of 2 or 3 on the final slot counts as 1. Any code of 3 in a sample sets `code_err_o` for that sample's word.
- R7: Code sets that differ only by a carry between neighbouring stages give the same word. For example, (2, 0) and (1, 2) in slots 0 and 1 both give 768 when the other slots hold 1 and the final bit is 1.
- R8: `word_o`, `word_vld_o` and `code_err_o` change only at the edge that ends a launch half. At the edge that ends an off half they hold their values.
- R9: A synchronous reset clears the alignment registers and the outputs. `word_vld_o` stays low until the first sample launched after reset has arrived.
- R10: With every redundant slot at 1, the word is 512 (10_0000_0000) when the final bit is 1 and 511 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; one cycle is one half conversion cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Marks a launch: slot 0 holds the first stage's code for a new sample |
| stg_code_i | input | 20 | Skewed stage-code bus, 2 bits per slot, slot 0 at the bottom |
| word_o | output | 10 | Corrected offset-binary word |
| word_vld_o | output | 1 | `word_o` holds a launched sample |
| code_err_o | output | 1 | The sample on `word_o` contained an illegal code 3 |

## Verification
Alignment and output timing compete in one cycle. The codes of two samples launched one full cycle apart share the bus in the same half-cycle. At the same time, an earlier word has to stay frozen across an off-half edge while the next sum is already being registered. The bench starts samples densely in back-to-back launch halves and adds stray strobes in off halves. It checks every half-cycle against a model driven by launch cycle: the word must belong to the correct sample, must hold for exactly two halves, and stray strobes must never become a valid word.

// File: rtl/adc_dc_pkg.sv
package adc_dc_pkg;
    localparam int unsigned CODE_W = 2;
    typedef logic [CODE_W-1:0] stg_code_t;
    localparam stg_code_t CODE_ILLEGAL = 2'd3;
    localparam stg_code_t CODE_TOP     = 2'd2;
endpackage

// File: rtl/adc_dc_deskew.sv
module adc_dc_deskew
    import adc_dc_pkg::*;
#(
    parameter int unsigned NSTG = 10
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [NSTG*CODE_W-1:0]   skew_i,
    output logic [NSTG*CODE_W-1:0]   aligned_o
);
    // slot k is held back NSTG-1-k half-cycles so every slot meets the last one
    for (genvar k = 0; k < NSTG; k++) begin : g_slot
        localparam int unsigned DLY = NSTG - 1 - k;
        if (DLY == 0) begin : g_pass
            assign aligned_o[k*CODE_W +: CODE_W] = skew_i[k*CODE_W +: CODE_W];
        end else begin : g_delay
            stg_code_t sh_d [DLY];
            stg_code_t sh_q [DLY];
            always_comb begin
                sh_d[0] = skew_i[k*CODE_W +: CODE_W];
                for (int j = 1; j < int'(DLY); j++) begin
                    sh_d[j] = sh_q[j-1];
                end
            end
            always_ff @(posedge clk_i) begin
                for (int j = 0; j < int'(DLY); j++) begin
                    if (rst_i) sh_q[j] <= '0;
                    else       sh_q[j] <= sh_d[j];
                end
            end
            assign aligned_o[k*CODE_W +: CODE_W] = sh_q[DLY-1];
        end
    end
endmodule

// File: rtl/adc_dc_merge.sv
module adc_dc_merge
    import adc_dc_pkg::*;
#(
    parameter int unsigned NSTG = 10
) (
    input  logic [NSTG*CODE_W-1:0] aligned_i,
    output logic [NSTG-1:0]        word_o,
    output logic                   err_o
);
    localparam int unsigned SUM_W = NSTG + 3;
    localparam int unsigned OFFS  = (1 << (NSTG - 1)) - 1;
    localparam int unsigned MAXV  = (1 << NSTG) - 1;

    stg_code_t                c;
    logic [SUM_W-1:0]         usum;
    logic signed [SUM_W-1:0]  sdiff;

    always_comb begin
        usum  = '0;
        err_o = 1'b0;
        for (int k = 0; k < int'(NSTG) - 1; k++) begin
            c = aligned_i[k*CODE_W +: CODE_W];
            if (c == CODE_ILLEGAL) begin
                c     = CODE_TOP;
                err_o = 1'b1;
            end
            usum = usum + (SUM_W'(c) << (int'(NSTG) - 1 - k));
        end
        c = aligned_i[(NSTG-1)*CODE_W +: CODE_W];
        if (c == CODE_ILLEGAL) err_o = 1'b1;
        usum  = usum + SUM_W'(c != '0);
        sdiff = $signed(usum) - $signed(SUM_W'(OFFS));
        if (sdiff < 0)                            word_o = '0;
        else if (sdiff > $signed(SUM_W'(MAXV)))   word_o = '1;
        else                                      word_o = sdiff[NSTG-1:0];
    end
endmodule

// File: rtl/adc_pipe_corr.sv
module adc_pipe_corr
    import adc_dc_pkg::*;
#(
    parameter int unsigned NSTG = 10
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   smp_vld_i,
    input  logic [NSTG*CODE_W-1:0] stg_code_i,
    output logic [NSTG-1:0]        word_o,
    output logic                   word_vld_o,
    output logic                   code_err_o
);
    localparam int unsigned OUT_W = NSTG;

    typedef struct packed {
        logic             ph;       // 0: launch half, 1: off half
        logic [NSTG-1:0]  vpipe;
        logic [OUT_W-1:0] sum;
        logic             sum_err;
        logic [OUT_W-1:0] word;
        logic             vld;
        logic             err;
    } corr_st_t;

    corr_st_t st_d, st_q;

    logic [NSTG*CODE_W-1:0] aligned;
    logic [OUT_W-1:0]       mword;
    logic                   merr;

    adc_dc_deskew #(.NSTG(NSTG)) u_deskew (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .skew_i    (stg_code_i),
        .aligned_o (aligned)
    );

    adc_dc_merge #(.NSTG(NSTG)) u_merge (
        .aligned_i (aligned),
        .word_o    (mword),
        .err_o     (merr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ph      = ~st_q.ph;
        st_d.vpipe   = {st_q.vpipe[NSTG-2:0], smp_vld_i & ~st_q.ph};
        st_d.sum     = mword;
        st_d.sum_err = merr;
        if (!st_q.ph) begin
            st_d.word = st_q.sum;
            st_d.err  = st_q.sum_err;
            st_d.vld  = st_q.vpipe[NSTG-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign word_o     = st_q.word;
    assign word_vld_o = st_q.vld;
    assign code_err_o = st_q.err;
endmodule

// File: rtl/adc_dc_check.sv
module adc_dc_check #(
    parameter int unsigned OUT_W = 10
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             smp_vld_i,
    input logic             ph_i,
    input logic             first_vld_i,
    input logic             word_vld_i,
    input logic [OUT_W-1:0] word_i,
    input logic             err_i
);
    AST_OFF_PHASE_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_vld_i && ph_i) |=> !first_vld_i); // R4

    AST_PHASE_ALTERNATES: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> (ph_i != $past(ph_i))); // R4

    AST_HOLD_AFTER_OFF_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
        !ph_i |-> ($stable(word_i) && $stable(word_vld_i) && $stable(err_i))); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!word_vld_i && word_i == '0 && !err_i)); // R9

    // eleven half-cycles at the default ten-stage depth
    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(word_vld_i) |-> $past(smp_vld_i, 11)); // R3
endmodule

bind adc_pipe_corr adc_dc_check #(.OUT_W(OUT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .smp_vld_i   (smp_vld_i),
    .ph_i        (st_q.ph),
    .first_vld_i (st_q.vpipe[0]),
    .word_vld_i  (word_vld_o),
    .word_i      (word_o),
    .err_i       (code_err_o)
);

// File: tb/adc_pipe_corr_bench.sv
module adc_pipe_corr_bench;
    localparam int NS   = 10;
    localparam int CW   = 2;
    localparam int MAXC = 700;
    localparam int LAT  = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic [NS*CW-1:0] bus = '0;
    logic [NS-1:0] word;
    logic word_vld, cerr;

    always #10 clk = ~clk;

    adc_pipe_corr u_adc_pipe_corr (
        .clk_i      (clk),
        .rst_i      (rst),
        .smp_vld_i  (smp_vld),
        .stg_code_i (bus),
        .word_o     (word),
        .word_vld_o (word_vld),
        .code_err_o (cerr)
    );

    int nchk = 0;
    int nerr = 0;
    logic [NS*CW-1:0] samp [512];
    string stag [512];
    int nsamp = 0;
    int nxt = 0;
    int launch_at [MAXC];
    bit junk_at [MAXC];

    function automatic int exp_raw(input logic [NS*CW-1:0] s);
        int acc = 0;
        int c;
        for (int k = 0; k < NS-1; k++) begin
            c = int'(s[k*CW +: CW]);
            if (c == 3) c = 2;
            acc += c << (NS-1-k);
        end
        c = int'(s[(NS-1)*CW +: CW]);
        acc += (c != 0) ? 1 : 0;
        return acc - ((1 << (NS-1)) - 1);
    endfunction

    function automatic int exp_word(input logic [NS*CW-1:0] s);
        int r = exp_raw(s);
        if (r < 0) return 0;
        if (r > (1 << NS) - 1) return (1 << NS) - 1;
        return r;
    endfunction

    function automatic bit exp_err(input logic [NS*CW-1:0] s);
        bit e = 1'b0;
        for (int k = 0; k < NS; k++) if (s[k*CW +: CW] == 2'd3) e = 1'b1;
        return e;
    endfunction

    function automatic logic [NS*CW-1:0] mk(input int base, input int last);
        logic [NS*CW-1:0] s;
        for (int k = 0; k < NS-1; k++) s[k*CW +: CW] = CW'(base);
        s[(NS-1)*CW +: CW] = CW'(last);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic add(input logic [NS*CW-1:0] s, input string t);
        samp[nsamp] = s;
        stag[nsamp] = t;
        nsamp++;
    endtask

    task automatic run(input int ncyc, input int rate);
        for (int i = 0; i < MAXC; i++) begin
            launch_at[i] = -1;
            junk_at[i]   = 1'b0;
        end
        for (int n = 0; n < ncyc; n++) begin
            int u;
            int src;
            int idx;
            bit go;
            @(negedge clk);
            // outputs of half-cycle n: last update edge closed launch half u-1
            u   = (n % 2 == 1) ? n : n - 1;
            src = u - LAT;
            if (src >= 0 && launch_at[src] >= 0) begin
                idx = launch_at[src];
                chk(word_vld == 1'b1, "R3", int'(word_vld), 1);
                chk(int'(word) == exp_word(samp[idx]),
                    (n % 2 == 0) ? "R8" : stag[idx], int'(word), exp_word(samp[idx]));
                chk(cerr == exp_err(samp[idx]), "R6", int'(cerr), int'(exp_err(samp[idx])));
            end else begin
                chk(word_vld == 1'b0,
                    (src < 0) ? "R9" :
                    ((junk_at[src+1] || (src > 0 && junk_at[src-1])) ? "R4" : "R3"),
                    int'(word_vld), 0);
            end
            if (n == 0) rst = 1'b0;
            go = (n % 2 == 0) && (n < ncyc - LAT - 2) && (nxt < nsamp)
                 && (($urandom % 4) < rate);
            launch_at[n] = go ? nxt : -1;
            if (go) nxt++;
            junk_at[n] = (n % 2 == 1) && (($urandom % 3) == 0);
            smp_vld = go || junk_at[n];
            for (int k = 0; k < NS; k++) begin
                if (n - k >= 0 && launch_at[n-k] >= 0)
                    bus[k*CW +: CW] = samp[launch_at[n-k]][k*CW +: CW];
                else
                    bus[k*CW +: CW] = CW'($urandom % 4);
            end
        end
    endtask

    initial begin
        logic [NS*CW-1:0] s;
        void'($urandom(32'h5eed));
        add(mk(2, 1), "R5");
        add(mk(0, 0), "R5");
        add(mk(1, 1), "R10");
        add(mk(1, 0), "R10");
        s = mk(1, 1); s[0 +: CW] = 2'd2; s[CW +: CW] = 2'd0; add(s, "R7");
        s = mk(1, 1); s[0 +: CW] = 2'd1; s[CW +: CW] = 2'd2; add(s, "R7");
        s = mk(1, 1); s[4*CW +: CW] = 2'd3; add(s, "R6");
        add(mk(1, 3), "R6");
        s = mk(0, 0); s[0 +: CW] = 2'd2; add(s, "R1");
        add(mk(1, 2), "R6");
        while (nsamp < 500) begin
            for (int k = 0; k < NS; k++) begin
                int r = int'($urandom % 16);
                s[k*CW +: CW] = (r < 5) ? 2'd0 : (r < 10) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
            end
            add(s, "R2");
        end

        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_vld == 1'b0, "R9", int'(word_vld), 0);
        chk(word == '0, "R9", int'(word), 0);
        chk(cerr == 1'b0, "R9", int'(cerr), 0);
        run(600, 3);

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(word_vld == 1'b0, "R9", int'(word_vld), 0);
        chk(word == '0, "R9", int'(word), 0);
        run(400, 4);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(20 * 200000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule